// File: doc/BRIEF.md
# Three-Operand Bitwise Truth-Table Unit

This execution unit evaluates any Boolean function of three inputs across every bit of three equal-width operand words. An 8-bit function code acts as a truth table: at each bit position the bits taken from operands X, Y and Z form a 3-bit row number, and the code bit at that row becomes the result bit at that position. No bit position affects any other.

The code comes either from an 8-bit immediate or, when the source-select input is high, from the low byte of a fourth word-wide operand. In that second form the unit acts as a row of identical 3-input lookup tables that are loaded at run time. A request presented with `req_valid` high is captured on the rising clock edge. The result and `rsp_valid` appear on the next edge.

Top module: `tri_logic_unit`

## Requirements
- R1: Result bit i equals bit (Z[i]*4 + Y[i]*2 + X[i]) of the selected 8-bit code. X supplies index bit 0, Y supplies index bit 1 and Z supplies index bit 2.
- R2: Each result bit depends only on the same bit position of the three operands and on the code.
- R3: Code 0x80 gives X & Y & Z, and code 0xFE gives X | Y | Z.
- R4: Code 0xCA gives a blend: Y where Z is 1, and X where Z is 0.
- R5: Code 0x00 gives all zeros and code 0xFF gives all ones, whatever the operands. Code 0xAA returns X unchanged.
- R6: When `code_sel` is 1 the code is `code_word[7:0]`, and `imm_code` is ignored. When `code_sel` is 0 the code is `imm_code`.
- R7: In word-sourced mode, bits of `code_word` above bit 7 have no effect on the result.
- R8: A request accepted with `req_valid` high at an edge produces its result, with `rsp_valid` high, after that same edge. After any edge that sees `req_valid` low, `rsp_valid` is low and `result` holds its previous value.
- R9: A synchronous active-high `rst` clears `result` to zero and `rsp_valid` to 0.
- R10: The operand width is set by the parameter `WIDTH`. The default is 64, and result width equals operand width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid; the operands are captured at the edge |
| code_sel | input | 1 | 0: use imm_code, 1: use code_word[7:0] |
| imm_code | input | 8 | Immediate truth-table code |
| code_word | input | WIDTH | Word operand that carries the code in its low byte |
| op_x | input | WIDTH | Operand X (index bit 0) |
| op_y | input | WIDTH | Operand Y (index bit 1) |
| op_z | input | WIDTH | Operand Z (index bit 2) |
| rsp_valid | output | 1 | Result valid |
| result | output | WIDTH | Registered result |

## Verification
The bench targets the index ordering. A design that swapped X and Z would turn the 0xCA blend into a different selection and would make 0xAA return Z instead of X. It drives operands that are non-zero only in the top bit, which catches a lookup that was wired or sliced wrongly at the last position. It sets junk in the upper bits of `code_word`, and a different value on `imm_code`, while in word-sourced mode; a leak through the code multiplexer then shows up as a wrong result. It also checks that idle cycles drop `rsp_valid` and leave `result` unchanged, which exposes a valid flag that stays set after the input goes idle.

// File: rtl/tri_logic_pkg.sv
package tri_logic_pkg;
   localparam int unsigned CODE_W = 8;
   localparam int unsigned IDX_W  = 3;
   typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/tri_code_mux.sv
module tri_code_mux #(
   parameter int unsigned WIDTH = 64
) (
   input  logic                        code_sel,
   input  tri_logic_pkg::code_t        imm_code,
   input  logic [WIDTH-1:0]            code_word,
   output tri_logic_pkg::code_t        code
);
   import tri_logic_pkg::*;

   initial begin
      if (WIDTH < CODE_W) $error("tri_code_mux: WIDTH must be at least CODE_W");
   end

   always_comb begin
      code = code_sel ? code_word[CODE_W-1:0] : imm_code;
   end
endmodule

// File: rtl/tri_lut_array.sv
module tri_lut_array #(
   parameter int unsigned WIDTH = 64
) (
   input  tri_logic_pkg::code_t   code,
   input  logic [WIDTH-1:0]       op_x,
   input  logic [WIDTH-1:0]       op_y,
   input  logic [WIDTH-1:0]       op_z,
   output logic [WIDTH-1:0]       lut_out
);
   import tri_logic_pkg::*;

   initial begin
      if (WIDTH < 1) $error("tri_lut_array: WIDTH must be positive");
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      logic [IDX_W-1:0] row;
      always_comb begin
         row        = {op_z[g], op_y[g], op_x[g]};
         lut_out[g] = code[row];
      end
   end
endmodule

// File: rtl/tri_logic_unit.sv
module tri_logic_unit #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             req_valid,
   input  logic             code_sel,
   input  logic [7:0]       imm_code,
   input  logic [WIDTH-1:0] code_word,
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   input  logic [WIDTH-1:0] op_z,
   output logic             rsp_valid,
   output logic [WIDTH-1:0] result
);
   import tri_logic_pkg::*;

   initial begin
      if (WIDTH < CODE_W) $error("tri_logic_unit: WIDTH below code width");
   end

   code_t            code;
   logic [WIDTH-1:0] lut_out;

   tri_code_mux #(.WIDTH(WIDTH)) u_mux (
      .code_sel (code_sel),
      .imm_code (imm_code),
      .code_word(code_word),
      .code     (code)
   );

   tri_lut_array #(.WIDTH(WIDTH)) u_lut (
      .code   (code),
      .op_x   (op_x),
      .op_y   (op_y),
      .op_z   (op_z),
      .lut_out(lut_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         rsp_valid <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) result <= lut_out;
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid) else $error("valid lost"); // R8
   AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!rsp_valid && $stable(result))) else $error("idle"); // R8
   AST_AND_CODE: assert property (@(posedge clk) disable iff (rst)
      (req_valid && code == 8'h80) |=> result == ($past(op_x) & $past(op_y) & $past(op_z)))
      else $error("and"); // R3
   AST_OR_CODE: assert property (@(posedge clk) disable iff (rst)
      (req_valid && code == 8'hFE) |=> result == ($past(op_x) | $past(op_y) | $past(op_z)))
      else $error("or"); // R3
   AST_BLEND_CODE: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !code_sel && imm_code == 8'hCA) |=>
         result == (($past(op_z) & $past(op_y)) | (~$past(op_z) & $past(op_x))))
      else $error("blend"); // R4
   AST_PASS_X: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !code_sel && imm_code == 8'hAA) |=> result == $past(op_x))
      else $error("pass"); // R5
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (!rsp_valid && result == '0)) else $error("reset"); // R9
endmodule

// File: tb/tb_tri_logic_unit.sv
module tb_tri_logic_unit;
   localparam int unsigned W = 64;

   logic clk = 0;
   logic rst, req_valid, code_sel;
   logic [7:0] imm_code;
   logic [W-1:0] code_word, op_x, op_y, op_z, result;
   logic rsp_valid;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tri_logic_unit #(.WIDTH(W)) dut (.*);

   function automatic logic [W-1:0] model(input logic [7:0] c,
         input logic [W-1:0] x, y, z);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = c[{z[i], y[i], x[i]}];
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic apply(input bit sel, input logic [7:0] imm,
         input logic [W-1:0] cw, x, y, z);
      @(negedge clk);
      req_valid = 1; code_sel = sel; imm_code = imm; code_word = cw;
      op_x = x; op_y = y; op_z = z;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic run(input string req, input bit sel, input logic [7:0] imm,
         input logic [W-1:0] cw, x, y, z, exp);
      apply(sel, imm, cw, x, y, z);
      check({req, " valid"}, {63'd0, rsp_valid}, 64'd1);
      check(req, result, exp);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] a, b, c, held;
      logic [7:0] k;
      void'($urandom(32'd1234));
      rst = 1; req_valid = 0; code_sel = 0; imm_code = 0;
      code_word = 0; op_x = 0; op_y = 0; op_z = 0;
      repeat (3) @(negedge clk);
      check("R9 reset result", result, '0);
      check("R9 reset valid", {63'd0, rsp_valid}, 64'd0);
      rst = 0;

      a = 64'hF0F0_1234_AAAA_0001; b = 64'hFF00_5678_CCCC_8000; c = 64'hFFFF_9ABC_F0F0_8001;
      run("R3 and", 0, 8'h80, '0, a, b, c, a & b & c);
      run("R3 or", 0, 8'hFE, '0, a, b, c, a | b | c);
      run("R4 blend", 0, 8'hCA, '0, a, b, c, (c & b) | (~c & a));
      run("R5 zero", 0, 8'h00, '0, a, b, c, '0);
      run("R5 ones", 0, 8'hFF, '0, a, b, c, '1);
      run("R5 pass X", 0, 8'hAA, '0, a, b, c, a);
      // R1 ordering: single-bit operands hitting rows 1,2,4 at the top bit
      run("R1 row1", 0, 8'h02, '0, 64'h8000_0000_0000_0000, '0, '0, 64'h8000_0000_0000_0000);
      run("R1 row2", 0, 8'h04, '0, '0, 64'h8000_0000_0000_0000, '0, 64'h8000_0000_0000_0000);
      run("R1 row4", 0, 8'h10, '0, '0, '0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
      // R2: one set bit in X only at bit 5, code 0x02 -> only bit 5 set
      run("R2 isolation", 0, 8'h02, '0, 64'h20, '0, '0, 64'h20);
      // R6/R7: word-sourced, junk above bit 7, different imm
      run("R6 R7 word code", 1, 8'h00, 64'hDEAD_BEEF_0000_33CA, a, b, c, (c & b) | (~c & a));
      run("R6 imm ignored", 1, 8'hFF, 64'hFFFF_FFFF_FFFF_FF80, a, b, c, a & b & c);

      for (int n = 0; n < 200; n++) begin
         a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
         k = 8'($urandom);
         if (n % 2 == 0) run("R1 R10 random imm", 0, k, {$urandom, $urandom}, a, b, c, model(k, a, b, c));
         else run("R7 random word", 1, 8'($urandom), {$urandom, $urandom, 24'd0, k} , a, b, c, model(k, a, b, c));
      end

      // R8 idle: valid drops, result held
      held = result;
      @(negedge clk);
      op_x = '1; op_y = '1; op_z = '1; imm_code = 8'hFF;
      @(negedge clk);
      check("R8 idle valid", {63'd0, rsp_valid}, 64'd0);
      check("R8 idle hold", result, held);

      // R9 reset mid-run
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R9 reset again", result, '0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule